// File: doc/BRIEF.md
# Signed-Digit Decimal Partial Product Generator

This block is the front end of a parallel decimal multiplier. It takes an unsigned multiplicand of `N` BCD-8421 digits and a multiplier of `N` BCD-8421 digits. It delivers the `N+1` partial products that a carry-save reduction tree sums into the product. Each partial product is `N+1` digits in BCD-4221 code and comes with a negative flag. Each multiplier digit is rewritten as a signed digit in the range -5..+5. This uses only a local carry from the next-lower digit, so nothing ripples. As a result, a partial product is always one of five precomputed multiples of the multiplicand, or zero, inverted when its digit is negative.

The multiples are built from digit recodings and fixed bit shifts. Two times comes from a BCD-5211 view shifted left by one bit. Five times comes from shifting the BCD-8421 operand left by three bits, which yields BCD-5421. Four times doubles the two-times word again. Three times is the only multiple that needs a BCD carry-propagate addition, of one times plus two times. An optional register after the multiples cuts this slow path.

A negative partial product is the bitwise inverse of its multiple, and the missing +1 of the 10's complement is left to the reduction tree as a carry-in, signalled by the flag. The block does not sign-extend each negative partial product with leading nines. Instead it emits one `2N`-digit padding word that equals the sum of all those extensions. The padding word only ever holds the digits 0, 8 and 9.

Top module: `sdpp_gen`

## Requirements
- R1: For digit position i below N, `pp_neg[i]` is 1 exactly when multiplier digit i is 5 or more. `pp_neg[N]` is always 0.
- R2: Define c_i = (digit i >= 5), with c_-1 = 0 and digit N = 0. The signed digit is s_i = digit_i - 10*c_i + c_(i-1), and for the top position s_N = c_(N-1). A partial product whose flag is 0 decodes to |s_i| times the multiplicand.
- R3: A partial product whose flag is 1 is the bitwise inverse of |s_i| times the multiplicand. Its decoded value v therefore satisfies 10^(N+1) - 1 - v = |s_i| * A. This includes a signed digit of zero, which then appears as all nines.
- R4: All output digits use BCD-4221 code, with bit weights 4, 2, 2, 1 from bit 3 down to bit 0. Digits 0..N of `pad` are zero. Its higher digits are 0 (0000), 8 (1110) or 9 (1111), and its value equals 10^(2N) minus the sum of 10^(i+N+1) over the negative positions i, taken modulo 10^(2N).
- R5: The sum of (pp_i + pp_neg[i]) * 10^i over all i, plus `pad`, taken modulo 10^(2N), equals A times B.
- R6: Outputs reflect the operands sampled 1 + PIPE_TRIPLE rising edges earlier. A new operand pair may be accepted every cycle.
- R7: While `rst_n` is low at a rising edge, all outputs become zero. The reset is synchronous and active low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a | input | 4*N | Multiplicand, BCD-8421, digit 0 in bits 3:0 |
| b | input | 4*N | Multiplier, BCD-8421, digit 0 in bits 3:0 |
| pp | output | (N+1)*(N+1)*4 | Partial products, product i in bits i*(N+1)*4 upward, BCD-4221 |
| pp_neg | output | N+1 | Negative flag (pending +1) per partial product |
| pad | output | 8*N | Merged sign-extension word, BCD-4221 |

## Verification
Two functions can act in the same cycle. The first is the inversion of a zero selection, where a digit of 9 receives a carry and becomes signed zero with its flag still set. The second is the nines-and-eights pattern of the padding word that this same flag feeds. Multipliers built from runs of nines and fives provoke both at once, and so do random operands streamed back to back. Each result is judged on three things: every partial product against |s_i| times A, the padding word against its closed form, and the full reassembled sum against A times B.

// File: rtl/sdpp_pkg.sv
// Shared digit-code helpers for the partial product generator.
// Assumes every digit passed in holds a value 0..9 in its source code.
package sdpp_pkg;

    typedef logic [3:0] nib_t;

    // BCD-4221 encoding of a value 0..9
    function automatic nib_t to4221(input nib_t v);
        case (v)
            4'd0: return 4'b0000;
            4'd1: return 4'b0001;
            4'd2: return 4'b0010;
            4'd3: return 4'b0011;
            4'd4: return 4'b1000;
            4'd5: return 4'b1001;
            4'd6: return 4'b1010;
            4'd7: return 4'b1011;
            4'd8: return 4'b1110;
            default: return 4'b1111;
        endcase
    endfunction

    // BCD-5211 encoding of a value 0..9
    function automatic nib_t to5211(input nib_t v);
        case (v)
            4'd0: return 4'b0000;
            4'd1: return 4'b0001;
            4'd2: return 4'b0100;
            4'd3: return 4'b0101;
            4'd4: return 4'b0111;
            4'd5: return 4'b1000;
            4'd6: return 4'b1001;
            4'd7: return 4'b1100;
            4'd8: return 4'b1101;
            default: return 4'b1111;
        endcase
    endfunction

    // BCD-5421 encoding of a value 0..9
    function automatic nib_t to5421(input nib_t v);
        return (v >= 4'd5) ? {1'b1, 3'(v - 4'd5)} : v;
    endfunction

    // value of a BCD-4221 digit
    function automatic nib_t of4221(input nib_t d);
        return (d[3] ? 4'd4 : 4'd0) + (d[2] ? 4'd2 : 4'd0) +
               (d[1] ? 4'd2 : 4'd0) + (d[0] ? 4'd1 : 4'd0);
    endfunction

    // value of a BCD-5421 digit
    function automatic nib_t of5421(input nib_t d);
        return (d[3] ? 4'd5 : 4'd0) + {1'b0, d[2:0]};
    endfunction

endpackage

// File: rtl/sdpp_recode.sv
// Rewrites each multiplier digit as a signed digit -5..+5 (magnitude and
// sign). The carry only moves one digit up, so there is no ripple.
// Assumes BCD-8421 input digits and N >= 2.
module sdpp_recode #(
    parameter int N = 4
) (
    input  logic [4*N-1:0]  b,
    output logic [N:0][2:0] mag,
    output logic [N:0]      neg
);
    logic [N-1:0] cy;
    logic [N-1:0] cin;

    for (genvar i = 0; i < N; i++) begin : g_dig
        logic [3:0] dig;
        logic [4:0] s;
        logic [4:0] ns;
        assign dig   = b[4*i +: 4];
        assign cy[i] = (dig >= 4'd5);
        if (i == 0) begin : g_lsd
            assign cin[i] = 1'b0;
        end else begin : g_up
            assign cin[i] = cy[i-1];
        end
        // signed digit = digit - 10*carry + carry from below
        always_comb begin
            s      = 5'(dig) - (cy[i] ? 5'd10 : 5'd0) + 5'(cin[i]);
            ns     = 5'd0 - s;
            mag[i] = s[4] ? ns[2:0] : s[2:0];
        end
        assign neg[i] = cy[i];
    end

    // extra top digit is the last carry, never negative
    assign mag[N] = {2'b00, cy[N-1]};
    assign neg[N] = 1'b0;

endmodule

// File: rtl/sdpp_multiples.sv
// Precomputes 1X..5X of the multiplicand in BCD-4221, N+1 digits each.
// 2X, 4X and 5X use recodings and fixed shifts; 3X uses a BCD-8421 adder.
// Assumes a BCD-8421 multiplicand.
module sdpp_multiples
    import sdpp_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [4*N-1:0]           x,
    output logic [4:0][(N+1)*4-1:0]  mults
);
    localparam int W = (N+1)*4;

    logic [W-1:0]   x_ext;
    logic [4*N-1:0] x5211;
    logic [4*N-1:0] x5421;
    logic [W-1:0]   m1, m2, m3, m4, m5;
    logic [W-1:0]   m2_5211, m5_5421, dbl8421, trip8421;

    assign x_ext   = {4'b0000, x};
    assign m2      = {3'b000, x5211, 1'b0};
    assign m4      = {m2_5211[W-2:0], 1'b0};
    assign m5_5421 = {1'b0, x, 3'b000};
    assign dbl8421 = {3'b000, x5421, 1'b0};

    // digit recodings of the multiplicand
    always_comb begin
        for (int i = 0; i < N; i++) begin
            x5211[4*i +: 4] = to5211(x[4*i +: 4]);
            x5421[4*i +: 4] = to5421(x[4*i +: 4]);
        end
    end

    // 1X, 4X-input and 5X digit conversions
    always_comb begin
        for (int i = 0; i < N+1; i++) begin
            m1[4*i +: 4]      = to4221(x_ext[4*i +: 4]);
            m2_5211[4*i +: 4] = to5211(of4221(m2[4*i +: 4]));
            m5[4*i +: 4]      = to4221(of5421(m5_5421[4*i +: 4]));
        end
    end

    // 3X: BCD-8421 carry-propagate addition of X and 2X
    always_comb begin
        logic       c;
        logic [4:0] t;
        c = 1'b0;
        for (int i = 0; i < N+1; i++) begin
            t = 5'(x_ext[4*i +: 4]) + 5'(dbl8421[4*i +: 4]) + 5'(c);
            if (t > 5'd9) begin
                trip8421[4*i +: 4] = 4'(t - 5'd10);
                c = 1'b1;
            end else begin
                trip8421[4*i +: 4] = t[3:0];
                c = 1'b0;
            end
            m3[4*i +: 4] = to4221(trip8421[4*i +: 4]);
        end
    end

    assign mults = {m5, m4, m3, m2, m1};

endmodule

// File: rtl/sdpp_select.sv
// Picks a multiple per signed digit and inverts it for negative digits.
// Inversion of a BCD-4221 digit gives 9 minus its value; the +1 is left
// to the reduction stage. Assumes magnitudes 0..5.
module sdpp_select #(
    parameter int N = 4
) (
    input  logic [4:0][(N+1)*4-1:0] mults,
    input  logic [N:0][2:0]         mag,
    input  logic [N:0]              neg,
    output logic [N:0][(N+1)*4-1:0] pp
);
    localparam int W = (N+1)*4;

    for (genvar i = 0; i <= N; i++) begin : g_pp
        logic [W-1:0] sel;
        // multiple mux followed by conditional inversion
        always_comb begin
            case (mag[i])
                3'd1:    sel = mults[0];
                3'd2:    sel = mults[1];
                3'd3:    sel = mults[2];
                3'd4:    sel = mults[3];
                3'd5:    sel = mults[4];
                default: sel = '0;
            endcase
            pp[i] = neg[i] ? ~sel : sel;
        end
    end

endmodule

// File: rtl/sdpp_pad.sv
// Builds the single word standing for all leading-nine sign extensions.
// Its value is the 10's complement of a 0/1 digit word, so it holds only
// 0, 8 and 9. Flags of positions N-1 and N fall outside 2N digits.
module sdpp_pad #(
    parameter int N = 4
) (
    input  logic [N-2:0]   neg_lo,
    output logic [8*N-1:0] pad
);
    // zeros below the lowest flagged digit, 9 there, 8/9 above it
    always_comb begin
        logic seen;
        logic q;
        seen = 1'b0;
        pad  = '0;
        for (int j = N+1; j < 2*N; j++) begin
            q = neg_lo[j-N-1];
            if (!seen) pad[4*j +: 4] = q ? 4'b1111 : 4'b0000;
            else       pad[4*j +: 4] = q ? 4'b1110 : 4'b1111;
            seen = seen | q;
        end
    end

endmodule

// File: rtl/sdpp_gen.sv
// Signed-digit decimal partial product generator (top).
// Latency is 1 + PIPE_TRIPLE cycles; PIPE_TRIPLE registers the multiples
// and recoded digits to cut the 3X adder path. Synchronous active-low reset.
module sdpp_gen #(
    parameter int N           = 4,
    parameter int PIPE_TRIPLE = 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [4*N-1:0]             a,
    input  logic [4*N-1:0]             b,
    output logic [(N+1)*(N+1)*4-1:0]   pp,
    output logic [N:0]                 pp_neg,
    output logic [8*N-1:0]             pad
);
    localparam int W = (N+1)*4;

    logic [4:0][W-1:0] mults_c, mults_s;
    logic [N:0][2:0]   mag_c, mag_s;
    logic [N:0]        neg_c, neg_s;
    logic [N:0][W-1:0] pp_c;
    logic [8*N-1:0]    pad_c;

    sdpp_multiples #(.N(N)) i_mult (.x(a), .mults(mults_c));
    sdpp_recode    #(.N(N)) i_rec  (.b(b), .mag(mag_c), .neg(neg_c));

    if (PIPE_TRIPLE != 0) begin : g_pipe
        // optional stage after multiple generation and recoding
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mults_s <= '0;
                mag_s   <= '0;
                neg_s   <= '0;
            end else begin
                mults_s <= mults_c;
                mag_s   <= mag_c;
                neg_s   <= neg_c;
            end
        end
    end else begin : g_flat
        assign mults_s = mults_c;
        assign mag_s   = mag_c;
        assign neg_s   = neg_c;
    end

    sdpp_select #(.N(N)) i_sel (.mults(mults_s), .mag(mag_s), .neg(neg_s), .pp(pp_c));
    sdpp_pad    #(.N(N)) i_pad (.neg_lo(neg_s[N-2:0]), .pad(pad_c));

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pp     <= '0;
            pp_neg <= '0;
            pad    <= '0;
        end else begin
            pp     <= pp_c;
            pp_neg <= neg_s;
            pad    <= pad_c;
        end
    end

endmodule

// File: rtl/sdpp_gen_chk.sv
// Assertion checker for sdpp_gen, attached by bind below.
// Uses a saturating counter so no check looks before reset release.
module sdpp_gen_chk #(
    parameter int N           = 4,
    parameter int PIPE_TRIPLE = 1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [4*N-1:0]           a,
    input logic [4*N-1:0]           b,
    input logic [(N+1)*(N+1)*4-1:0] pp,
    input logic [N:0]               pp_neg,
    input logic [8*N-1:0]           pad
);
    localparam int LAT = 1 + PIPE_TRIPLE;
    localparam int W   = (N+1)*4;

    logic [3:0] cnt;

    // cycles since reset release, saturating at LAT
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= 4'd0;
        else if (cnt < 4'(LAT))    cnt <= cnt + 4'd1;
    end

    function automatic logic pad_ok(input logic [8*N-1:0] p);
        logic ok;
        ok = 1'b1;
        for (int j = 0; j < 2*N; j++) begin
            if (j <= N) ok = ok & (p[4*j +: 4] == 4'b0000);
            else        ok = ok & ((p[4*j +: 4] == 4'b0000) ||
                                   (p[4*j +: 4] == 4'b1110) ||
                                   (p[4*j +: 4] == 4'b1111));
        end
        return ok;
    endfunction

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pp == '0 && pp_neg == '0 && pad == '0)); // R7

    AST_TOP_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
        pp_neg[N] == 1'b0); // R1

    AST_PAD_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        pad_ok(pad)); // R4

    for (genvar i = 0; i < N; i++) begin : g_flag
        AST_NEG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt >= 4'(LAT)) |->
            (pp_neg[i] == ($past(b[4*i +: 4], LAT) >= 4'd5))); // R1
    end

    for (genvar i = 0; i <= N; i++) begin : g_zero
        AST_ZERO_MULTIPLICAND: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt >= 4'(LAT) && $past(a, LAT) == '0) |->
            (pp[i*W +: W] == (pp_neg[i] ? {W{1'b1}} : {W{1'b0}}))); // R3
    end

endmodule

bind sdpp_gen sdpp_gen_chk #(.N(N), .PIPE_TRIPLE(PIPE_TRIPLE)) i_chk (
    .clk(clk), .rst_n(rst_n), .a(a), .b(b),
    .pp(pp), .pp_neg(pp_neg), .pad(pad)
);

// File: tb/test_sdpp_gen.sv
`timescale 1ns/1ps
// Directed bench for sdpp_gen: one task per scenario, each checking itself.
module test_sdpp_gen;
    localparam int N    = 4;
    localparam int PIPE = 1;
    localparam int LAT  = 1 + PIPE;
    localparam int W    = (N+1)*4;

    logic                 clk   = 1'b0;
    logic                 rst_n = 1'b0;
    logic [4*N-1:0]       a     = '0;
    logic [4*N-1:0]       b     = '0;
    logic [(N+1)*W-1:0]   pp;
    logic [N:0]           pp_neg;
    logic [8*N-1:0]       pad;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    sdpp_gen #(.N(N), .PIPE_TRIPLE(PIPE)) i_sdpp_gen (
        .clk(clk), .rst_n(rst_n), .a(a), .b(b),
        .pp(pp), .pp_neg(pp_neg), .pad(pad)
    );

    function automatic longint pow10(input int e);
        longint r = 1;
        for (int k = 0; k < e; k++) r = r * 10;
        return r;
    endfunction

    // value of a BCD-4221 word (weights 4,2,2,1), nd digits
    function automatic longint dec4221(input logic [8*N-1:0] v, input int nd);
        longint r = 0;
        for (int k = nd-1; k >= 0; k--)
            r = r * 10 + 4*v[4*k+3] + 2*v[4*k+2] + 2*v[4*k+1] + v[4*k];
        return r;
    endfunction

    function automatic longint from_bcd(input logic [4*N-1:0] v);
        longint r = 0;
        for (int k = N-1; k >= 0; k--) r = r * 10 + v[4*k +: 4];
        return r;
    endfunction

    function automatic logic [4*N-1:0] rand_bcd();
        logic [4*N-1:0] r;
        for (int k = 0; k < N; k++) r[4*k +: 4] = 4'($urandom % 10);
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // compares current outputs with the operands av, bv
    task automatic verify(input logic [4*N-1:0] av, input logic [4*N-1:0] bv,
                          input string ctx, output bit all_ok);
        longint A = from_bcd(av);
        longint B = from_bcd(bv);
        longint total = 0;
        longint q = 0;
        longint mod2n = pow10(2*N);
        int c_prev = 0;
        all_ok = 1'b1;
        for (int i = 0; i <= N; i++) begin
            int d = (i < N) ? int'(bv[4*i +: 4]) : 0;
            int c = (i < N && d >= 5) ? 1 : 0;
            int s = d - 10*c + c_prev;
            int m = (s < 0) ? -s : s;
            logic [8*N-1:0] slice = '0;
            longint val, got;
            c_prev = c;
            // R1: flag follows the digit's own carry
            chk(pp_neg[i] == c[0], {"R1 ", ctx}, longint'(pp_neg[i]), longint'(c));
            if (pp_neg[i] != c[0]) all_ok = 1'b0;
            slice[W-1:0] = pp[i*W +: W];
            val = dec4221(slice, N+1);
            got = pp_neg[i] ? (pow10(N+1) - 1 - val) : val;
            // R2 positive selection, R3 inverted selection
            chk(got == m * A, pp_neg[i] ? {"R3 ", ctx} : {"R2 ", ctx}, got, m * A);
            if (got != m * A) all_ok = 1'b0;
            total = total + (val + longint'(pp_neg[i])) * pow10(i);
            if (c == 1 && i + N + 1 < 2*N) q = q + pow10(i + N + 1);
        end
        // R4: padding word in closed form and digit set
        begin
            longint pexp = (mod2n - q) % mod2n;
            longint pgot = dec4221(pad, 2*N);
            bit codes = 1'b1;
            for (int j = 0; j < 2*N; j++) begin
                if (j <= N) codes &= (pad[4*j +: 4] == 4'b0000);
                else codes &= (pad[4*j +: 4] inside {4'b0000, 4'b1110, 4'b1111});
            end
            chk(codes && pgot == pexp, {"R4 ", ctx}, pgot, pexp);
            if (!(codes && pgot == pexp)) all_ok = 1'b0;
            total = (total + pgot) % mod2n;
        end
        // R5: reassembled product
        chk(total == A * B, {"R5 ", ctx}, total, A * B);
        if (total != A * B) all_ok = 1'b0;
    endtask

    task automatic apply_check(input logic [4*N-1:0] av, input logic [4*N-1:0] bv,
                               input string ctx);
        bit ok;
        @(negedge clk);
        a = av;
        b = bv;
        repeat (LAT) @(posedge clk);
        @(negedge clk);
        verify(av, bv, ctx, ok);
    endtask

    task automatic t_reset();
        @(negedge clk);
        a = 16'h9876;
        b = 16'h5959;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(pp == '0 && pp_neg == '0 && pad == '0, "R7 reset clears outputs",
            longint'(pp_neg), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_zero();
        apply_check(16'h0000, 16'h0000, "zero both");
        apply_check(16'h0000, 16'h9595, "zero multiplicand");
        apply_check(16'h4321, 16'h0000, "zero multiplier");
    endtask

    task automatic t_nines();
        // digit 9 with incoming carry recodes to signed zero, flag set
        apply_check(16'h9999, 16'h9999, "all nines");
        apply_check(16'h0001, 16'h9999, "nines multiplier");
    endtask

    task automatic t_fives();
        apply_check(16'h5555, 16'h5555, "all fives");
        apply_check(16'h9999, 16'h4545, "fours and fives");
        apply_check(16'h1234, 16'h3333, "triple path");
        apply_check(16'h0007, 16'h5000, "top digit five");
    endtask

    task automatic t_random();
        for (int k = 0; k < 20; k++) apply_check(rand_bcd(), rand_bcd(), "random");
    endtask

    task automatic t_stream();
        logic [4*N-1:0] sa [6];
        logic [4*N-1:0] sb [6];
        for (int k = 0; k < 6; k++) begin
            sa[k] = rand_bcd();
            sb[k] = rand_bcd();
        end
        sb[2] = 16'h9999;
        for (int k = 0; k < 6 + LAT; k++) begin
            @(negedge clk);
            if (k >= LAT) begin
                bit ok;
                verify(sa[k-LAT], sb[k-LAT], "stream", ok);
                // R6: back-to-back operands appear LAT cycles later
                chk(ok, "R6 streaming latency", longint'(ok), 1);
            end
            if (k < 6) begin
                a = sa[k];
                b = sb[k];
            end
        end
    endtask

    initial begin
        #1000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_zero();
        t_nines();
        t_fives();
        t_random();
        t_stream();
        t_reset();
        apply_check(16'h9999, 16'h9595, "after second reset");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule